// File: doc/BRIEF.md
# Serial Control Register Interface

This block is the control-port front end of a telephone audio device. A host sends 9-bit commands over three wires: a data line, a shift clock and an active-low latch strobe. Each command holds a 4-bit register address and 5 data bits. When the strobe falls, the most recent 9 bits are written into the addressed register.

Two registers exist. The first drives four general-purpose latch outputs directly. The second holds a 2-bit ratio field that divides an incoming tone reference clock by 1, 2 or 4. Three mode pins are decoded into enable signals for the reference, tone and full-function domains.

All host-side inputs are asynchronous. They are brought into the system clock domain through two-flop synchronizers before any edge detection or decoding.

Top module: `ser_ctrl_port`

## Requirements
- R1: A frame is 9 bits sampled on each rising edge of `ser_clk`, sent first bit first: address bits A3..A0, then data bits D4..D0; only the last 9 bits shifted before a commit count.
- R2: A command is committed once per falling edge of `ser_strobe_n`; bits shifted while the strobe stays low change no register until the next falling edge.
- R3: A commit to address 4'b1000 sets `ext_latch[i]` to data bit Di for i = 0..3; D4 is not used.
- R4: A commit to address 4'b1110 loads D4:D3 as the tone ratio: 2'b00 divides by 1, 2'b01 by 2, 2'b10 by 4, 2'b11 by 1; D2..D0 are not used.
- R5: A commit to any other address changes neither `ext_latch` nor the tone ratio.
- R6: While `rst_n` is low, `ext_latch` is 0 and all enables are 0; after reset the tone ratio is divide by 1.
- R7: Mode pins `pmode[2:0]` decode as follows: 000 gives all enables 0; 100 gives `en_ref` only; x10 gives `en_ref` and `en_tone`; xx1 gives all three enables.
- R8: When a strobe falling edge and a `ser_clk` rising edge reach the logic in the same cycle, the commit uses the 9 bits held before that shift.
- R9: In divide-by-2 and divide-by-4 modes, `tone_clk` toggles only on rising edges of the synchronized `tone_ref`, giving a 50% duty cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_data | input | 1 | Serial command data |
| ser_clk | input | 1 | Serial shift clock; data is taken on its rising edge |
| ser_strobe_n | input | 1 | Active-low commit strobe |
| pmode | input | 3 | Power mode select pins |
| tone_ref | input | 1 | Tone generator reference clock |
| ext_latch | output | 4 | General-purpose latch outputs |
| tone_clk | output | 1 | Divided tone clock |
| en_ref | output | 1 | Reference domain enable |
| en_tone | output | 1 | Tone domain enable |
| en_all | output | 1 | Full-function enable |

## Verification
The commit and the shift can fall in the same cycle. This happens when a strobe falling edge and a serial clock rising edge cross the synchronizers together. The bench provokes it by driving both pin changes on the same system clock edge, with a stray data bit on the line after a complete frame. The test passes only if the latch outputs show that complete frame, not the frame shifted by one more bit. In a second case, new ratios are committed while the tone reference is running. The output edge rate is then counted over a fixed window for each ratio.

// File: rtl/ser_ctrl_port.sv
module ser_ctrl_port #(
  parameter int FRAME_W = 9,
  parameter int ADDR_W  = 4,
  parameter int LATCH_W = 4,
  parameter int SYNC_N  = 2,
  parameter logic [ADDR_W-1:0] LATCH_ADDR = 4'b1000,
  parameter logic [ADDR_W-1:0] TONE_ADDR  = 4'b1110
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               ser_data,
  input  logic               ser_clk,
  input  logic               ser_strobe_n,
  input  logic [2:0]         pmode,
  input  logic               tone_ref,
  output logic [LATCH_W-1:0] ext_latch,
  output logic               tone_clk,
  output logic               en_ref,
  output logic               en_tone,
  output logic               en_all
);
  localparam int DATA_W = FRAME_W - ADDR_W;
  localparam int IN_W   = 7;
  localparam logic [IN_W-1:0] SYNC_RST = 7'b000_0100;

  logic [IN_W-1:0] sync_q [SYNC_N];
  logic [IN_W-1:0] s;
  logic sclk_d, strb_d, tref_d;
  logic sclk_rise, commit, t_rise;
  logic [FRAME_W-1:0] shreg;
  logic [ADDR_W-1:0]  cmd_addr;
  logic [DATA_W-1:0]  cmd_data;
  logic [1:0] div_sel;
  logic       div_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_N; i++) sync_q[i] <= SYNC_RST;
    end else begin
      sync_q[0] <= {pmode, tone_ref, ser_strobe_n, ser_data, ser_clk};
      for (int i = 1; i < SYNC_N; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  assign s = sync_q[SYNC_N-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d <= 1'b0;
      strb_d <= 1'b1;
      tref_d <= 1'b0;
    end else begin
      sclk_d <= s[0];
      strb_d <= s[2];
      tref_d <= s[3];
    end
  end

  assign sclk_rise = s[0] & ~sclk_d;
  assign commit    = strb_d & ~s[2];
  assign t_rise    = s[3] & ~tref_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else if (sclk_rise) shreg <= {shreg[FRAME_W-2:0], s[1]};
  end

  assign cmd_addr = shreg[FRAME_W-1 -: ADDR_W];
  assign cmd_data = shreg[DATA_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_latch <= '0;
      div_sel   <= 2'b00;
    end else if (commit) begin
      if (cmd_addr == LATCH_ADDR) ext_latch <= cmd_data[LATCH_W-1:0];
      if (cmd_addr == TONE_ADDR)  div_sel   <= cmd_data[4:3];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tone_clk <= 1'b0;
      div_cnt  <= 1'b0;
    end else begin
      case (div_sel)
        2'b01: if (t_rise) tone_clk <= ~tone_clk;
        2'b10: if (t_rise) begin
          div_cnt <= ~div_cnt;
          if (div_cnt) tone_clk <= ~tone_clk;
        end
        default: begin
          tone_clk <= s[3];
          div_cnt  <= 1'b0;
        end
      endcase
    end
  end

  assign en_all  = s[4];
  assign en_tone = s[4] | s[5];
  assign en_ref  = s[4] | s[5] | s[6];
endmodule

module ser_ctrl_port_chk #(
  parameter int ADDR_W  = 4,
  parameter int LATCH_W = 4,
  parameter logic [ADDR_W-1:0] LATCH_ADDR = 4'b1000,
  parameter logic [ADDR_W-1:0] TONE_ADDR  = 4'b1110
) (
  input logic               clk,
  input logic               rst_n,
  input logic               commit,
  input logic [ADDR_W-1:0]  cmd_addr,
  input logic [LATCH_W-1:0] ext_latch,
  input logic [1:0]         div_sel,
  input logic               t_rise,
  input logic               tone_clk,
  input logic               en_ref,
  input logic               en_tone,
  input logic               en_all
);
  // R2
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(ext_latch));
  // R4
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> $stable(div_sel));
  // R5
  foreign_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && cmd_addr != LATCH_ADDR && cmd_addr != TONE_ADDR)
    |=> ($stable(ext_latch) && $stable(div_sel)));
  // R9
  tone_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!t_rise && (div_sel == 2'b01 || div_sel == 2'b10)) |=> $stable(tone_clk));
  // R7
  enable_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_all |-> en_tone) and (en_tone |-> en_ref));
endmodule

bind ser_ctrl_port ser_ctrl_port_chk #(
  .ADDR_W(ADDR_W), .LATCH_W(LATCH_W),
  .LATCH_ADDR(LATCH_ADDR), .TONE_ADDR(TONE_ADDR)
) u_chk (
  .clk(clk), .rst_n(rst_n), .commit(commit), .cmd_addr(cmd_addr),
  .ext_latch(ext_latch), .div_sel(div_sel), .t_rise(t_rise),
  .tone_clk(tone_clk), .en_ref(en_ref), .en_tone(en_tone), .en_all(en_all)
);

// File: tb/tb_ser_ctrl_port.sv
`timescale 1ns/1ps
module tb_ser_ctrl_port;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ser_data = 1'b0, ser_clk = 1'b0, ser_strobe_n = 1'b1, tone_ref = 1'b0;
  logic [2:0] pmode = 3'b000;
  logic [3:0] ext_latch;
  logic tone_clk, en_ref, en_tone, en_all;
  int total = 0, bad = 0;

  always #10 clk = ~clk;
  always #80 tone_ref = ~tone_ref;

  ser_ctrl_port dut (
    .clk(clk), .rst_n(rst_n), .ser_data(ser_data), .ser_clk(ser_clk),
    .ser_strobe_n(ser_strobe_n), .pmode(pmode), .tone_ref(tone_ref),
    .ext_latch(ext_latch), .tone_clk(tone_clk),
    .en_ref(en_ref), .en_tone(en_tone), .en_all(en_all)
  );

  // {addr, data, expected latch, expected ratio code 0:/1 1:/2 2:/4}
  localparam logic [14:0] VEC [8] = '{
    {4'b1000, 5'b10110, 4'b0110, 2'd0},
    {4'b1110, 5'b01000, 4'b0110, 2'd1},
    {4'b1110, 5'b10000, 4'b0110, 2'd2},
    {4'b0011, 5'b11111, 4'b0110, 2'd2},
    {4'b1000, 5'b01001, 4'b1001, 2'd2},
    {4'b1110, 5'b11000, 4'b1001, 2'd0},
    {4'b1111, 5'b10101, 4'b1001, 2'd0},
    {4'b1110, 5'b00111, 4'b1001, 2'd0}
  };

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic shift_frame(input logic [3:0] a, input logic [4:0] d);
    logic [8:0] bits;
    bits = {a, d};
    for (int i = 8; i >= 0; i--) begin
      ser_data = bits[i];
      wait_n(4);
      ser_clk = 1'b1;
      wait_n(4);
      ser_clk = 1'b0;
    end
    wait_n(2);
  endtask

  task automatic strobe;
    ser_strobe_n = 1'b0;
    wait_n(6);
    ser_strobe_n = 1'b1;
    wait_n(4);
  endtask

  task automatic rate(output int n);
    logic prev;
    n = 0;
    prev = tone_clk;
    repeat (256) begin
      @(negedge clk);
      if (tone_clk && !prev) n++;
      prev = tone_clk;
    end
  endtask

  task automatic chk_rate(input string tag, input int code);
    int n, e;
    e = (code == 1) ? 16 : (code == 2) ? 8 : 32;
    rate(n);
    chk(n >= e - 1 && n <= e + 1, tag, n, e);
  endtask

  initial begin
    #3_000_000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait_n(3);
    // R6 reset state
    chk(ext_latch == 4'b0000, "R6 latch in reset", ext_latch, 0);
    chk({en_ref, en_tone, en_all} == 3'b000, "R6 enables in reset", {en_ref, en_tone, en_all}, 0);
    rst_n = 1'b1;
    wait_n(4);
    chk_rate("R6 ratio after reset", 0);

    // R1 R3 R4 R5 table walk
    foreach (VEC[k]) begin
      shift_frame(VEC[k][14:11], VEC[k][10:6]);
      strobe();
      chk(ext_latch == VEC[k][5:2], $sformatf("R3/R5 vec%0d latch", k), ext_latch, VEC[k][5:2]);
      chk_rate($sformatf("R4/R9 vec%0d ratio", k), VEC[k][1:0]);
    end

    // R7 mode decode
    for (int m = 0; m < 8; m++) begin
      logic [2:0] e;
      pmode = m[2:0];
      wait_n(4);
      if (m[0])      e = 3'b111;
      else if (m[1]) e = 3'b110;
      else if (m[2]) e = 3'b100;
      else           e = 3'b000;
      chk({en_ref, en_tone, en_all} == e, $sformatf("R7 pmode=%0d", m), {en_ref, en_tone, en_all}, e);
    end

    // R2 strobe held low: one commit per falling edge
    shift_frame(4'b1000, 5'b00011);
    ser_strobe_n = 1'b0;
    wait_n(6);
    chk(ext_latch == 4'b0011, "R2 first commit", ext_latch, 3);
    shift_frame(4'b1000, 5'b01100);
    chk(ext_latch == 4'b0011, "R2 no update while low", ext_latch, 3);
    ser_strobe_n = 1'b1;
    wait_n(6);
    chk(ext_latch == 4'b0011, "R2 no update on rise", ext_latch, 3);
    strobe();
    chk(ext_latch == 4'b1100, "R2 second falling edge", ext_latch, 12);

    // R8 strobe fall and shift edge together
    shift_frame(4'b1000, 5'b00101);
    strobe();
    chk(ext_latch == 4'b0101, "R8 setup", ext_latch, 5);
    shift_frame(4'b1000, 5'b01010);
    ser_data = 1'b1;
    ser_clk = 1'b1;
    ser_strobe_n = 1'b0;
    wait_n(6);
    chk(ext_latch == 4'b1010, "R8 commit before shift", ext_latch, 10);
    ser_clk = 1'b0;
    ser_strobe_n = 1'b1;
    wait_n(4);

    // R1 trailing frame wins over earlier bits
    shift_frame(4'b0000, 5'b11111);
    shift_frame(4'b1000, 5'b00110);
    strobe();
    chk(ext_latch == 4'b0110, "R1 last nine bits", ext_latch, 6);

    // R6 reset mid-run
    shift_frame(4'b1110, 5'b10000);
    strobe();
    chk_rate("R4 divide by 4 before reset", 2);
    pmode = 3'b111;
    rst_n = 1'b0;
    wait_n(3);
    chk(ext_latch == 4'b0000, "R6 latch cleared", ext_latch, 0);
    chk({en_ref, en_tone, en_all} == 3'b000, "R6 enables cleared", {en_ref, en_tone, en_all}, 0);
    rst_n = 1'b1;
    wait_n(4);
    chk_rate("R6 ratio back to 1", 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule